// File: doc/BRIEF.md
# SPI Slave Descriptor Engine

This block is a serial-peripheral slave that moves 8-bit characters between the SPI pins and two small local buffers. Each buffer has a descriptor: the transmit descriptor holds a ready flag and a byte length, and the receive descriptor holds an open (empty) flag and a fill count. An external master drives the serial clock, data and select. The block only follows that clock, so it has no baud generator.

Software loads the transmit buffer, arms the descriptors and pulses `start`. The master can then assert select and clock the bytes through. Each direction is completed on its own terms. The transmit side closes as soon as its programmed length has been shifted out. The receive side closes when it is full, or when select is negated with at least one byte stored. A byte that arrives while no receive buffer is open is dropped and flagged as an error.

Closure and error events go into a write-one-to-clear event register, and a maskable interrupt line is derived from it. The serial inputs pass through two-flop synchronizers, so the system clock must run at least four times faster than SCK.

Top module: `spi_bd_slave`

## Requirements
- R1: SPI mode 0 with MSB first. MOSI is sampled on rising SCK and MISO changes on falling SCK. When armed and the transmit descriptor is ready, MISO carries transmit-buffer entries in order starting at entry 0, and the first bit is present once select is asserted.
- R2: If `start` has not been pulsed, a select period has no effect: MISO shifts all ones, nothing is written to the receive buffer, no event bit is set and both descriptors keep their state.
- R3: The transmit descriptor closes (`tx_ready` low, event bit 1 set) during the byte that completes `tx_len` bytes, even while the master keeps clocking. Every byte shifted while no transmit descriptor is ready is 0xFF.
- R4: Received bytes are stored at buffer addresses 0, 1, 2 and upward in arrival order, and `rx_count` reports how many are held.
- R5: Negating select with a partly filled receive buffer (at least one byte) closes it: `rx_empty` drops and event bit 0 is set. `tx_ready` is not affected.
- R6: The receive descriptor closes with event bit 0 and no error when it holds RX_DEPTH bytes. A later negation of select raises no error.
- R7: A byte completed while armed with the receive descriptor closed sets event bit 2 and is discarded: the buffer contents and `rx_count` stay unchanged.
- R8: Event bits are: bit 0 receive closed, bit 1 transmit closed, bit 2 out-of-buffers error. All are 0 after reset, and each is cleared by a 1 in the same position of `evt_clr`.
- R9: `irq` is high exactly when some event bit is set together with its bit in `evt_mask`.
- R10: When one byte completes both the transmit length and a full receive buffer, event bits 0 and 1 are set in the same clock cycle.
- R11: Negation of select disarms the engine. A later select period without a new `start` pulse is ignored as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ssel_n | input | 1 | Slave select, active low |
| spi_miso | output | 1 | Serial data to the master |
| start | input | 1 | Pulse: arm the engine for the next select period |
| tx_arm | input | 1 | Pulse: mark the transmit descriptor ready with length `tx_len` |
| tx_len | input | 5 | Transmit byte count (1 to TX_DEPTH) |
| tx_wr_en | input | 1 | Write strobe for the transmit buffer |
| tx_wr_addr | input | 4 | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| tx_ready | output | 1 | Transmit descriptor open |
| rx_arm | input | 1 | Pulse: open the receive descriptor with a count of zero |
| rx_empty | output | 1 | Receive descriptor open |
| rx_count | output | 5 | Bytes held in the receive buffer |
| rx_rd_addr | input | 4 | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer data at `rx_rd_addr` |
| evt | output | 3 | Event register |
| evt_clr | input | 3 | Write-one-to-clear strobes for `evt` |
| evt_mask | input | 3 | Interrupt enables per event bit |
| irq | output | 1 | Masked OR of the event bits |

## Verification
The transmit close and the receive close can be caused by the same received character. The bench provokes this by programming a transmit length equal to the receive depth and clocking exactly that many bytes. A monitor records the clock cycle in which each of the two event bits rises, and the check requires both cycles to be equal. It also requires the event register to read both bits together before select is released.

// File: rtl/spi_bd_pkg.sv
package spi_bd_pkg;
  localparam int EV_W   = 3;
  localparam int EV_RX  = 0;
  localparam int EV_TX  = 1;
  localparam int EV_ERR = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              sel,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_from_bd,
  output logic              miso,
  output logic              byte_done,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              done_from_bd,
  output logic              sel_end
);
  localparam int CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic              sck_q, sel_q;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [CHAR_W-2:0] rx_q, rx_n;
  logic [CHAR_W-1:0] tx_q, tx_n;
  logic              bd_q, bd_n;
  logic              rise, fall, sel_start;

  assign rise      = sel & sck_s & ~sck_q;
  assign fall      = sel & ~sck_s & sck_q;
  assign sel_start = sel & ~sel_q;
  assign sel_end   = ~sel & sel_q;

  assign byte_done    = rise && (bit_q == LAST);
  assign rx_byte      = {rx_q, mosi_s};
  assign done_from_bd = bd_q;
  assign miso         = sel ? tx_q[CHAR_W-1] : 1'b1;

  always_comb begin
    bit_n = bit_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    bd_n  = bd_q;
    if (!sel) begin
      bit_n = '0;
      tx_n  = '1;
      bd_n  = 1'b0;
    end else if (sel_start) begin
      bit_n = '0;
      tx_n  = tx_data;
      bd_n  = tx_from_bd;
    end else if (rise) begin
      rx_n  = {rx_q[CHAR_W-3:0], mosi_s};
      bit_n = (bit_q == LAST) ? '0 : bit_q + CNT_W'(1);
    end else if (fall) begin
      if (bit_q == '0) begin
        tx_n = tx_data;
        bd_n = tx_from_bd;
      end else begin
        tx_n = {tx_q[CHAR_W-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '1;
      bd_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel;
      bit_q <= bit_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      bd_q  <= bd_n;
    end
  end

  AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_q == '0)); // R1
endmodule

// File: rtl/spi_bd_ctrl.sv
module spi_bd_ctrl
  import spi_bd_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_AW = $clog2(TX_DEPTH),
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_AW = $clog2(RX_DEPTH),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_arm,
  input  logic [TX_LW-1:0]  tx_len_in,
  input  logic              tx_wr_en,
  input  logic [TX_AW-1:0]  tx_wr_addr,
  input  logic [CHAR_W-1:0] tx_wr_data,
  input  logic              rx_arm,
  input  logic [RX_AW-1:0]  rx_rd_addr,
  input  logic [EV_W-1:0]   evt_clr,
  input  logic              byte_done,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              done_from_bd,
  input  logic              sel_end,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_from_bd,
  output logic [CHAR_W-1:0] rx_rd_data,
  output logic              tx_ready,
  output logic              rx_empty,
  output logic [RX_CW-1:0]  rx_count,
  output logic [EV_W-1:0]   evt
);
  localparam logic [RX_CW-1:0] RX_FULL = RX_CW'(RX_DEPTH);

  logic [CHAR_W-1:0] tx_mem [TX_DEPTH];
  logic [CHAR_W-1:0] rx_mem [RX_DEPTH];

  logic              armed_q, armed_n;
  logic              txr_q, txr_n;
  logic [TX_LW-1:0]  tlen_q, tlen_n, tptr_q, tptr_n;
  logic              rxe_q, rxe_n;
  logic [RX_CW-1:0]  rcnt_q, rcnt_n;
  logic [EV_W-1:0]   ev_q, ev_n, ev_set;
  logic              rx_wr;

  assign tx_from_bd = armed_q & txr_q;
  assign tx_data    = tx_from_bd ? tx_mem[tptr_q[TX_AW-1:0]] : '1;
  assign rx_rd_data = rx_mem[rx_rd_addr];
  assign tx_ready   = txr_q;
  assign rx_empty   = rxe_q;
  assign rx_count   = rcnt_q;
  assign evt        = ev_q;

  always_comb begin
    armed_n = armed_q;
    txr_n   = txr_q;
    tlen_n  = tlen_q;
    tptr_n  = tptr_q;
    rxe_n   = rxe_q;
    rcnt_n  = rcnt_q;
    ev_set  = '0;
    rx_wr   = 1'b0;

    if (sel_end) armed_n = 1'b0;
    if (start)   armed_n = 1'b1;

    if (tx_arm && (tx_len_in != '0)) begin
      txr_n  = 1'b1;
      tptr_n = '0;
      tlen_n = tx_len_in;
    end else if (byte_done && armed_q && done_from_bd && txr_q) begin
      tptr_n = tptr_q + TX_LW'(1);
      if (tptr_q + TX_LW'(1) == tlen_q) begin
        txr_n          = 1'b0;
        ev_set[EV_TX]  = 1'b1;
      end
    end

    if (rx_arm) begin
      rxe_n  = 1'b1;
      rcnt_n = '0;
    end else if (byte_done && armed_q) begin
      if (rxe_q) begin
        rx_wr  = 1'b1;
        rcnt_n = rcnt_q + RX_CW'(1);
        if (rcnt_q + RX_CW'(1) == RX_FULL) begin
          rxe_n         = 1'b0;
          ev_set[EV_RX] = 1'b1;
        end
      end else begin
        ev_set[EV_ERR] = 1'b1;
      end
    end else if (sel_end && armed_q && rxe_q && (rcnt_q != '0)) begin
      rxe_n         = 1'b0;
      ev_set[EV_RX] = 1'b1;
    end

    ev_n = (ev_q & ~evt_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      txr_q   <= 1'b0;
      tlen_q  <= '0;
      tptr_q  <= '0;
      rxe_q   <= 1'b0;
      rcnt_q  <= '0;
      ev_q    <= '0;
    end else begin
      armed_q <= armed_n;
      txr_q   <= txr_n;
      tlen_q  <= tlen_n;
      tptr_q  <= tptr_n;
      rxe_q   <= rxe_n;
      rcnt_q  <= rcnt_n;
      ev_q    <= ev_n;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr_en) tx_mem[tx_wr_addr] <= tx_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rx_wr) rx_mem[rcnt_q[RX_AW-1:0]] <= rx_byte;
  end

  AST_TX_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    txr_q |-> (tptr_q < tlen_q)); // R3
  AST_TX_CLOSE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txr_q) |-> ev_q[EV_TX]); // R3
  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= RX_FULL); // R6
  AST_RX_CLOSE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxe_q) |-> ev_q[EV_RX]); // R5
  AST_ERR_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[EV_ERR]) |-> !$past(rxe_q)); // R7
  AST_DISARM_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && !start) |=> !armed_q); // R11
endmodule

// File: rtl/spi_bd_slave.sv
module spi_bd_slave
  import spi_bd_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_AW = $clog2(TX_DEPTH),
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_AW = $clog2(RX_DEPTH),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ssel_n,
  output logic              spi_miso,
  input  logic              start,
  input  logic              tx_arm,
  input  logic [TX_LW-1:0]  tx_len,
  input  logic              tx_wr_en,
  input  logic [TX_AW-1:0]  tx_wr_addr,
  input  logic [CHAR_W-1:0] tx_wr_data,
  output logic              tx_ready,
  input  logic              rx_arm,
  output logic              rx_empty,
  output logic [RX_CW-1:0]  rx_count,
  input  logic [RX_AW-1:0]  rx_rd_addr,
  output logic [CHAR_W-1:0] rx_rd_data,
  output logic [EV_W-1:0]   evt,
  input  logic [EV_W-1:0]   evt_clr,
  input  logic [EV_W-1:0]   evt_mask,
  output logic              irq
);
  logic [2:0]        sync_q;
  logic              byte_done, done_from_bd, sel_end, tx_from_bd;
  logic [CHAR_W-1:0] rx_byte, tx_data;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_ssel_n, spi_mosi, spi_sck}),
    .q     (sync_q)
  );

  spi_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_s        (sync_q[0]),
    .mosi_s       (sync_q[1]),
    .sel          (~sync_q[2]),
    .tx_data      (tx_data),
    .tx_from_bd   (tx_from_bd),
    .miso         (spi_miso),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .done_from_bd (done_from_bd),
    .sel_end      (sel_end)
  );

  spi_bd_ctrl #(.CHAR_W(CHAR_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tx_arm       (tx_arm),
    .tx_len_in    (tx_len),
    .tx_wr_en     (tx_wr_en),
    .tx_wr_addr   (tx_wr_addr),
    .tx_wr_data   (tx_wr_data),
    .rx_arm       (rx_arm),
    .rx_rd_addr   (rx_rd_addr),
    .evt_clr      (evt_clr),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .done_from_bd (done_from_bd),
    .sel_end      (sel_end),
    .tx_data      (tx_data),
    .tx_from_bd   (tx_from_bd),
    .rx_rd_data   (rx_rd_data),
    .tx_ready     (tx_ready),
    .rx_empty     (rx_empty),
    .rx_count     (rx_count),
    .evt          (evt)
  );

  assign irq = |(evt & evt_mask);
endmodule

// File: tb/sim_spi_bd_slave.sv
module sim_spi_bd_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_ssel_n = 1'b1;
  logic       spi_miso;
  logic       start = 1'b0, tx_arm = 1'b0, tx_wr_en = 1'b0, rx_arm = 1'b0;
  logic [4:0] tx_len = '0;
  logic [3:0] tx_wr_addr = '0, rx_rd_addr = '0;
  logic [7:0] tx_wr_data = '0, rx_rd_data;
  logic       tx_ready, rx_empty, irq;
  logic [4:0] rx_count;
  logic [2:0] evt, evt_clr = '0, evt_mask = '0;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  spi_bd_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_ssel_n(spi_ssel_n), .spi_miso(spi_miso), .start(start),
    .tx_arm(tx_arm), .tx_len(tx_len), .tx_wr_en(tx_wr_en),
    .tx_wr_addr(tx_wr_addr), .tx_wr_data(tx_wr_data), .tx_ready(tx_ready),
    .rx_arm(rx_arm), .rx_empty(rx_empty), .rx_count(rx_count),
    .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data), .evt(evt),
    .evt_clr(evt_clr), .evt_mask(evt_mask), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // scoreboard: expected MISO bytes queued by the driver, compared by the monitor
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mi_last;
  event       mi_ev;

  initial begin
    forever begin
      @(mi_ev);
      if (exp_q.size() == 0) check("scoreboard-underflow", 1, 0);
      else check(tag_q.pop_front(), mi_last, exp_q.pop_front());
    end
  end

  // R10 monitor: cycle time at which each close bit rises
  logic p_rx = 0, p_tx = 0;
  longint t_rx = 0, t_tx = 0;
  always @(negedge clk) begin
    if (evt[0] && !p_rx) t_rx = $time;
    if (evt[1] && !p_tx) t_tx = $time;
    p_rx = evt[0];
    p_tx = evt[1];
  end

  task automatic spi_byte(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag);
    logic [7:0] mi;
    exp_q.push_back(exp_mi);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = mo[i];
      #60 spi_sck = 1'b1;
      mi[i] = spi_miso;
      #60 spi_sck = 1'b0;
    end
    mi_last = mi;
    -> mi_ev;
  endtask

  task automatic sel_on();  spi_ssel_n = 1'b0; #100; endtask
  task automatic sel_off(); #100 spi_ssel_n = 1'b1; #100; endtask

  task automatic do_start(); @(negedge clk) start = 1'b1; @(negedge clk) start = 1'b0; endtask
  task automatic do_rx_arm(); @(negedge clk) rx_arm = 1'b1; @(negedge clk) rx_arm = 1'b0; endtask
  task automatic do_tx_arm(input logic [4:0] n);
    @(negedge clk) begin tx_arm = 1'b1; tx_len = n; end
    @(negedge clk) tx_arm = 1'b0;
  endtask
  task automatic do_clr(input logic [2:0] b);
    @(negedge clk) evt_clr = b;
    @(negedge clk) evt_clr = '0;
    @(negedge clk);
  endtask
  task automatic load_tx(input logic [7:0] base);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) begin tx_wr_en = 1'b1; tx_wr_addr = 4'(i); tx_wr_data = base + 8'(i); end
    end
    @(negedge clk) tx_wr_en = 1'b0;
  endtask
  task automatic rd_rx(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk) rx_rd_addr = 4'(a);
    #1 check(tag, rx_rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset miso idle", spi_miso, 1);
    check("R8 reset evt", evt, 0);
    check("R9 reset irq", irq, 0);
    check("R3 reset tx_ready", tx_ready, 0);
    check("R5 reset rx_empty", rx_empty, 0);

    // R2: no start, select period ignored
    load_tx(8'hC0);
    do_tx_arm(5'd5);
    do_rx_arm();
    sel_on();
    spi_byte(8'h11, 8'hFF, "R2 miso unarmed");
    spi_byte(8'h22, 8'hFF, "R2 miso unarmed");
    sel_off();
    check("R2 evt", evt, 0);
    check("R2 rx_count", rx_count, 0);
    check("R2 rx_empty", rx_empty, 1);
    check("R2 tx_ready", tx_ready, 1);

    // R1/R4/R5: 3 bytes then negate select
    do_start();
    sel_on();
    spi_byte(8'hA0, 8'hC0, "R1 tx byte0");
    spi_byte(8'hA1, 8'hC1, "R1 tx byte1");
    spi_byte(8'hA2, 8'hC2, "R1 tx byte2");
    sel_off();
    check("R5 rx closed", rx_empty, 0);
    check("R5 evt rx only", evt, 3'b001);
    check("R5 tx stays open", tx_ready, 1);
    check("R4 rx_count", rx_count, 3);
    rd_rx(0, 8'hA0, "R4 rx data0");
    rd_rx(1, 8'hA1, "R4 rx data1");
    rd_rx(2, 8'hA2, "R4 rx data2");
    do_clr(3'b001);
    check("R8 w1c clear", evt, 0);

    // R3: tx closes after its 5th byte
    do_rx_arm();
    do_start();
    sel_on();
    spi_byte(8'hB0, 8'hC3, "R1 tx byte3");
    spi_byte(8'hB1, 8'hC4, "R1 tx byte4");
    #100;
    check("R3 tx closed", tx_ready, 0);
    check("R3 evt tx", evt, 3'b010);
    spi_byte(8'hB2, 8'hFF, "R3 ones after close");
    spi_byte(8'hB3, 8'hFF, "R3 ones after close");
    sel_off();
    check("R5 evt both", evt, 3'b011);
    check("R4 rx_count 4", rx_count, 4);
    rd_rx(3, 8'hB3, "R4 rx data3");

    // R9 masking, R8 selective clear
    @(negedge clk) evt_mask = 3'b000;
    #1 check("R9 mask none", irq, 0);
    @(negedge clk) evt_mask = 3'b100;
    #1 check("R9 mask err only", irq, 0);
    @(negedge clk) evt_mask = 3'b001;
    #1 check("R9 mask rx", irq, 1);
    @(negedge clk) evt_mask = 3'b111;
    do_clr(3'b010);
    check("R8 clear tx bit", evt, 3'b001);
    check("R9 irq rx left", irq, 1);
    do_clr(3'b001);
    check("R8 clear rx bit", evt, 0);
    check("R9 irq low", irq, 0);

    // R6/R10: 16 bytes, tx length 16 -> both close on the same byte
    load_tx(8'h50);
    do_tx_arm(5'd16);
    do_rx_arm();
    do_start();
    sel_on();
    for (int i = 0; i < 16; i++) spi_byte(8'h80 + 8'(i), 8'h50 + 8'(i), "R1 tx full run");
    #100;
    check("R10 both bits", evt, 3'b011);
    check("R10 same cycle", (t_rx == t_tx) ? 1 : 0, 1);
    check("R6 rx closed full", rx_empty, 0);
    check("R6 rx_count full", rx_count, 16);
    sel_off();
    check("R6 no error on negate", evt, 3'b011);
    rd_rx(0, 8'h80, "R4 full data0");
    rd_rx(15, 8'h8F, "R4 full data15");
    do_clr(3'b111);

    // R7: 17th byte on a full buffer
    do_rx_arm();
    do_start();
    sel_on();
    for (int i = 0; i < 16; i++) spi_byte(8'h90 + 8'(i), 8'hFF, "R3 ones no tx bd");
    #100;
    check("R6 full no error", evt, 3'b001);
    spi_byte(8'hEE, 8'hFF, "R3 ones no tx bd");
    #100;
    check("R7 error raised", evt, 3'b101);
    check("R7 count unchanged", rx_count, 16);
    rd_rx(15, 8'h9F, "R7 last entry kept");
    rd_rx(0, 8'h90, "R7 first entry kept");
    sel_off();
    check("R7 evt after negate", evt, 3'b101);
    do_clr(3'b111);

    // R11: disarmed after negation, no new start
    do_rx_arm();
    sel_on();
    spi_byte(8'h5A, 8'hFF, "R11 miso ignored");
    sel_off();
    check("R11 evt", evt, 0);
    check("R11 rx_empty", rx_empty, 1);
    check("R11 rx_count", rx_count, 0);

    #200;
    finish_run();
  end
endmodule